// File: doc/BRIEF.md
# Dual-Master Bus Ownership Selector

This block sits between two bus masters, called side A and side B, and one downstream bus. Each side has its own small register port with a control register and an interrupt-status register. The block decides which side owns the downstream bus and whether that bus is switched on. It drives a route select and an enable toward the bus switch.

Ownership and the on/off state are never held as one shared bit. Each is a pair: a bit that the viewing side writes, and a read-only mirror of the bit the other side writes. Ownership and on/off follow from whether the two bits of a pair match. A side changes the state by reading its control register and then writing its own bit to match or differ from the mirror. Either side can raise an ownership request that the other side sees. If ownership is taken away while the bus stays on, the side that lost it gets a sticky bus-lost flag.

Read data is registered and appears one cycle after the read strobe. Writes take effect at the clock edge that samples them.

Top module: `bus_owner_sel`

## Requirements
- R1: Sub-address 0x01 selects the control register and 0x02 selects the status register. A read of any other sub-address returns 0x00, and a write to any other sub-address changes nothing.
- R2: A control write stores wdata bit 0 (own bit), bit 2 (on bit), bit 4 (init bit) and bit 7 (request bit). Bits 1, 3, 5 and 6 of the written byte are ignored. On read, the control register shows bit 0 own, bit 1 own mirror, bit 2 on, bit 3 on mirror, bit 4 init, bit 5 zero, bit 6 request mirror and bit 7 request.
- R3: Side A's mirrors are side B's own, on and request bits. Side B's on and request mirrors are side A's bits, and side B's own mirror is side A's own bit inverted.
- R4: A side owns the bus when bits 0 and 1 of its control view are equal. Exactly one side owns at any time. `sel_b` is 1 when side B owns, and it changes only after a control write.
- R5: `bus_en` is 1 when bits 2 and 3 of the control view differ, and 0 when they are equal.
- R6: Control bit 7 written by one side appears as status bit 7 and control bit 6 of the other side, and as status bit 6 of the writing side.
- R7: When a side writes a control byte that holds its current on-mirror value in bit 2 and zeros elsewhere, `bus_en` is 0 afterwards, provided the other side does not write control in the same cycle.
- R8: If `sel_b` changes while `bus_en` is 1 both before and after the change, the side that owned the bus before gets status bit 3 (bus-lost) set one cycle later.
- R9: A status read returns the current flags and then clears that side's bus-lost and init-done flags. A second read shows them at 0.
- R10: Status bit 0 follows `irq_in`. Status bit 2 (bus-ok) is 1 exactly when `bus_en` is 1 and that side owns the bus.
- R11: A control write with bit 4 set makes status bit 1 (init-done) of the writing side 1.
- R12: After reset all written bits are 0. The bus is off, side A owns it (`sel_b` = 0), side A's control reads 0x00 and side B's reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | Interrupt line shown in both status registers |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | ADDR_W | Side A sub-address |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A read data, valid the cycle after a_rd |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | ADDR_W | Side B sub-address |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B read data, valid the cycle after b_rd |
| sel_b | output | 1 | Route the downstream bus to side B (1) or side A (0) |
| bus_en | output | 1 | Downstream bus switched on |

## Verification
The bench writes to the mirror positions and to unmapped addresses. A design that stored those bits would show them on read-back and move `bus_en` or `sel_b`. It takes ownership over from side B while the bus stays on and then reads side A's status twice. This shows whether bus-lost lands on the real loser and whether it clears on read, since a design with the sides swapped or with the clear missing returns the wrong second value. It runs the release write to check that `bus_en` drops without a false bus-lost. It reads side B's control view after reset, which shows whether the ownership mirror is inverted, since a design without the inversion would report both sides as owner.

// File: rtl/bos_pkg.sv
package bos_pkg;
  localparam int REG_W = 8;
  localparam logic [7:0] CTRL_SUBADDR = 8'h01;
  localparam logic [7:0] STAT_SUBADDR = 8'h02;

  // control view bit positions (a neighbour's read-modify-write depends on them)
  localparam int C_OWN   = 0;
  localparam int C_OWN_M = 1;
  localparam int C_ON    = 2;
  localparam int C_ON_M  = 3;
  localparam int C_INIT  = 4;
  localparam int C_REQ_M = 6;
  localparam int C_REQ   = 7;

  // status view bit positions
  localparam int S_IRQ   = 0;
  localparam int S_INIT  = 1;
  localparam int S_OK    = 2;
  localparam int S_LOST  = 3;
  localparam int S_REQ   = 6;
  localparam int S_REQ_M = 7;

  typedef struct packed {
    logic req;
    logic init;
    logic on;
    logic own;
  } loc_t;

  function automatic loc_t take_local(input logic [REG_W-1:0] d);
    loc_t l;
    l.own  = d[C_OWN];
    l.on   = d[C_ON];
    l.init = d[C_INIT];
    l.req  = d[C_REQ];
    return l;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_view(input loc_t l, input logic own_m,
                                                 input logic on_m, input logic req_m);
    logic [REG_W-1:0] v;
    v = '0;
    v[C_OWN]   = l.own;
    v[C_OWN_M] = own_m;
    v[C_ON]    = l.on;
    v[C_ON_M]  = on_m;
    v[C_INIT]  = l.init;
    v[C_REQ_M] = req_m;
    v[C_REQ]   = l.req;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] stat_view(input logic irq, input logic init_done,
                                                 input logic ok, input logic lost,
                                                 input logic req_l, input logic req_m);
    logic [REG_W-1:0] v;
    v = '0;
    v[S_IRQ]   = irq;
    v[S_INIT]  = init_done;
    v[S_OK]    = ok;
    v[S_LOST]  = lost;
    v[S_REQ]   = req_l;
    v[S_REQ_M] = req_m;
    return v;
  endfunction

  // a pair of bits "matches" when both halves agree
  function automatic logic pair_match(input logic a, input logic b);
    return ~(a ^ b);
  endfunction
endpackage

// File: rtl/bos_side.sv
module bos_side
  import bos_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter bit INV_OWN_MIRROR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              peer_own,
  input  logic              peer_on,
  input  logic              peer_req,
  input  logic              bus_on,
  input  logic              irq,
  input  logic              lost_set,
  output logic              loc_own,
  output logic              loc_on,
  output logic              loc_req,
  output logic              owns,
  output logic              lost,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_SUBADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_SUBADDR);

  loc_t             loc_q;
  logic             init_done_q;
  logic             lost_q;
  logic [REG_W-1:0] rdata_q;
  logic             own_m;
  logic             ctrl_wr;
  logic             stat_rd;
  logic             bus_ok;

  generate
    if (INV_OWN_MIRROR) begin : g_inv_mirror
      assign own_m = ~peer_own;
    end else begin : g_plain_mirror
      assign own_m = peer_own;
    end
  endgenerate

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign stat_rd = rd && (addr == A_STAT);
  assign owns    = pair_match(loc_q.own, own_m);
  assign bus_ok  = bus_on && owns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_q <= '0;
    end else if (ctrl_wr) begin
      loc_q <= take_local(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_done_q <= 1'b0;
      lost_q      <= 1'b0;
    end else begin
      if (ctrl_wr && wdata[C_INIT]) init_done_q <= 1'b1;
      else if (stat_rd)             init_done_q <= 1'b0;
      if (lost_set)                 lost_q <= 1'b1;
      else if (stat_rd)             lost_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      if (addr == A_CTRL)      rdata_q <= ctrl_view(loc_q, own_m, peer_on, peer_req);
      else if (addr == A_STAT) rdata_q <= stat_view(irq, init_done_q, bus_ok, lost_q,
                                                    loc_q.req, peer_req);
      else                     rdata_q <= '0;
    end
  end

  assign loc_own = loc_q.own;
  assign loc_on  = loc_q.on;
  assign loc_req = loc_q.req;
  assign lost    = lost_q;
  assign rdata   = rdata_q;

  // R2: writable control bits land in local state
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CTRL) |=> (loc_own == $past(wdata[C_OWN]) && loc_on == $past(wdata[C_ON])
                                && loc_req == $past(wdata[C_REQ])));
  // R1: unmapped sub-address reads return zero
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr != A_CTRL && addr != A_STAT) |=> (rdata == '0));
  // R9: status read clears bus-lost unless a new loss arrives
  a_r9_read_clears_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_STAT && !lost_set) |=> !lost);
  // R11: init write raises init-done
  a_r11_init_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CTRL && wdata[C_INIT]) |=> init_done_q);
endmodule

// File: rtl/bus_owner_sel.sv
module bus_owner_sel
  import bos_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [REG_W-1:0]  a_wdata,
  output logic [REG_W-1:0]  a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [REG_W-1:0]  b_wdata,
  output logic [REG_W-1:0]  b_rdata,
  output logic              sel_b,
  output logic              bus_en
);
  localparam int N_SIDE = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_SUBADDR);

  logic [N_SIDE-1:0] wr, rd, own_l, on_l, req_l, owns, lost_set, lost;
  logic [ADDR_W-1:0] addr  [N_SIDE];
  logic [REG_W-1:0]  wdata [N_SIDE];
  logic [REG_W-1:0]  rdata [N_SIDE];
  logic              sel_prev_q, en_prev_q, flip;

  assign wr       = {b_wr, a_wr};
  assign rd       = {b_rd, a_rd};
  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;
  assign a_rdata  = rdata[0];
  assign b_rdata  = rdata[1];

  // ownership: A owns when own bits match; bus on when on bits differ
  assign sel_b  = own_l[0] ^ own_l[1];
  assign bus_en = on_l[0] ^ on_l[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b0;
      en_prev_q  <= 1'b0;
    end else begin
      sel_prev_q <= sel_b;
      en_prev_q  <= bus_en;
    end
  end

  // owner moved while the bus stayed on
  assign flip = (sel_b != sel_prev_q) && bus_en && en_prev_q;

  for (genvar i = 0; i < N_SIDE; i++) begin : g_side
    assign lost_set[i] = flip && ((i == 0) ? !sel_prev_q : sel_prev_q);

    bos_side #(
      .ADDR_W        (ADDR_W),
      .INV_OWN_MIRROR(i == 1)
    ) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr[i]),
      .rd      (rd[i]),
      .addr    (addr[i]),
      .wdata   (wdata[i]),
      .peer_own(own_l[N_SIDE-1-i]),
      .peer_on (on_l[N_SIDE-1-i]),
      .peer_req(req_l[N_SIDE-1-i]),
      .bus_on  (bus_en),
      .irq     (irq_in),
      .lost_set(lost_set[i]),
      .loc_own (own_l[i]),
      .loc_on  (on_l[i]),
      .loc_req (req_l[i]),
      .owns    (owns[i]),
      .lost    (lost[i]),
      .rdata   (rdata[i])
    );
  end

  // R4: the two side decodes always agree on a single owner
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(owns) == 1);
  // R4: route only moves after a control write
  a_r4_move_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b != $past(sel_b)) |-> $past((a_wr && a_addr == A_CTRL) || (b_wr && b_addr == A_CTRL)));
  // R8: the previous owner is flagged one cycle after losing a live bus
  a_r8_loser_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b != $past(sel_b) && bus_en && $past(bus_en)) |=> ($past(sel_b, 2) ? lost[1] : lost[0]));
  // R7: release write from A turns the bus off
  a_r7_release_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_addr == A_CTRL && a_wdata == (REG_W'(on_l[1]) << C_ON)
     && !(b_wr && b_addr == A_CTRL)) |=> !bus_en);
  // R7: release write from B turns the bus off
  a_r7_release_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && b_addr == A_CTRL && b_wdata == (REG_W'(on_l[0]) << C_ON)
     && !(a_wr && a_addr == A_CTRL)) |=> !bus_en);
endmodule

// File: tb/bus_owner_sel_bench.sv
module bus_owner_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_in = 1'b0;
  logic       a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [7:0] a_addr = 0, a_wdata = 0, b_addr = 0, b_wdata = 0;
  logic [7:0] a_rdata, b_rdata;
  logic       sel_b, bus_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] exp_qa[$], exp_qb[$];
  string      tag_qa[$], tag_qb[$];
  logic       pend_a = 0, pend_b = 0;

  always #5 clk = ~clk;

  bus_owner_sel u_bus_owner_sel (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .sel_b(sel_b), .bus_en(bus_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read data is valid the cycle after the strobe was sampled
  always @(posedge clk) begin
    pend_a <= a_rd;
    pend_b <= b_rd;
  end

  always @(negedge clk) begin
    if (pend_a) begin
      if (exp_qa.size() == 0) chk("scoreboard A underflow", 8'h00, 8'h01);
      else chk(tag_qa.pop_front(), a_rdata, exp_qa.pop_front());
    end
    if (pend_b) begin
      if (exp_qb.size() == 0) chk("scoreboard B underflow", 8'h00, 8'h01);
      else chk(tag_qb.pop_front(), b_rdata, exp_qb.pop_front());
    end
  end

  task automatic wr_reg(input bit side_b, input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    if (side_b) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else        begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input bit side_b, input logic [7:0] ad, input logic [7:0] exp,
                        input string tag);
    @(negedge clk);
    if (side_b) begin exp_qb.push_back(exp); tag_qb.push_back(tag); b_rd = 1; b_addr = ad; end
    else        begin exp_qa.push_back(exp); tag_qa.push_back(tag); a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  localparam logic [7:0] CT = 8'h01;
  localparam logic [7:0] ST = 8'h02;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    chk("R12 sel_b after reset", {7'b0, sel_b}, 8'h00);
    chk("R12 bus_en after reset", {7'b0, bus_en}, 8'h00);
    rd_reg(0, CT, 8'h00, "R12 A ctrl after reset");
    rd_reg(1, CT, 8'h02, "R12 R3 B ctrl after reset (inverted own mirror)");
    rd_reg(0, ST, 8'h00, "R12 A status after reset");

    // R5: A turns bus on
    wr_reg(0, CT, 8'h04);
    chk("R5 bus_en on after A on-bit", {7'b0, bus_en}, 8'h01);
    chk("R4 A still owner", {7'b0, sel_b}, 8'h00);
    rd_reg(0, ST, 8'h04, "R10 A bus-ok while owning live bus");
    rd_reg(1, CT, 8'h0A, "R3 B ctrl mirrors A on-bit");
    rd_reg(1, ST, 8'h00, "R10 B no bus-ok without ownership");

    // R2: mirror positions ignored
    wr_reg(0, CT, 8'h4E);
    rd_reg(0, CT, 8'h04, "R2 mirror bits of write ignored");
    chk("R2 bus_en unchanged", {7'b0, bus_en}, 8'h01);

    // R1: unmapped addresses
    wr_reg(0, 8'h03, 8'hFF);
    rd_reg(0, 8'h03, 8'h00, "R1 unmapped read zero");
    rd_reg(0, 8'h00, 8'h00, "R1 sub-address 0 reads zero");
    rd_reg(0, CT, 8'h04, "R1 unmapped write left ctrl");
    chk("R1 sel_b unchanged", {7'b0, sel_b}, 8'h00);

    // R6: B requests ownership
    wr_reg(1, CT, 8'h80);
    rd_reg(0, ST, 8'h84, "R6 A status shows B request");
    rd_reg(1, ST, 8'h40, "R6 B status shows own request");
    rd_reg(0, CT, 8'h44, "R6 A ctrl request mirror");

    // R8: B takes ownership while the bus stays on
    wr_reg(1, CT, 8'h81);
    chk("R4 sel_b to B", {7'b0, sel_b}, 8'h01);
    chk("R8 bus stays on", {7'b0, bus_en}, 8'h01);
    rd_reg(0, ST, 8'h88, "R8 A bus-lost set");
    rd_reg(0, ST, 8'h80, "R9 A bus-lost cleared by read");
    rd_reg(1, ST, 8'h44, "R8 B no bus-lost, bus-ok");
    rd_reg(1, CT, 8'h8B, "R3 R4 B ctrl as owner");

    // R7: B releases
    wr_reg(1, CT, 8'h04);
    chk("R7 bus off after release", {7'b0, bus_en}, 8'h00);
    chk("R4 A owner after release", {7'b0, sel_b}, 8'h00);
    rd_reg(1, ST, 8'h00, "R7 B no bus-lost on release");
    rd_reg(0, ST, 8'h00, "R7 A no bus-lost on release");

    // R11 R10: init and irq
    irq_in = 1;
    wr_reg(0, CT, 8'h14);
    rd_reg(0, CT, 8'h1C, "R11 A ctrl with init bit");
    rd_reg(0, ST, 8'h03, "R11 R10 A init-done and irq");
    rd_reg(0, ST, 8'h01, "R9 A init-done cleared by read");

    // R10: bus-ok for A
    wr_reg(0, CT, 8'h00);
    chk("R5 bus on when on-bits differ", {7'b0, bus_en}, 8'h01);
    rd_reg(0, ST, 8'h05, "R10 A irq and bus-ok");
    rd_reg(1, ST, 8'h01, "R10 B irq only");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(exp_qa.size() + exp_qb.size()), 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule